// File: doc/BRIEF.md
# Memory Bit-Field Operation Unit

This unit carries out one bit-field operation at a time on big-endian, byte-addressed memory. A command supplies a base byte address, a signed bit offset, a length code, an opcode and an insert value. The unit works out the field's starting byte address and its in-byte bit offset, then reads every byte the field touches through a one-byte memory port. From those bytes it forms a result word and two condition flags, N and Z. For the opcodes that modify memory, it writes the touched bytes back in ascending address order.

Both edges of the unit use a valid/ready handshake. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the unit is idle. A memory transaction completes on a cycle where `mem_req_valid` and `mem_req_ready` are both high. For a read, `mem_rdata` is sampled in that same cycle. The memory side may hold `mem_req_ready` low for any number of cycles. While it does, the unit keeps its request unchanged. The outcome of the command is given by a one-cycle `done` pulse with `result`, `flag_n` and `flag_z` valid in that cycle.

Top module: `bitfield_mem_unit`

## Requirements
- R1: A length code of 0 selects a 32-bit field. Any other code k selects a field of k bits.
- R2: The first byte address is the base plus the bit offset divided by 8, rounded toward negative infinity. The in-byte bit offset is the offset modulo 8, in the range 0..7. Negative offsets therefore reach bytes below the base.
- R3: The unit reads exactly ((in-byte offset + length - 1) / 8) + 1 bytes, from one to five, starting at the first byte address.
- R4: Field bit 0 is the most significant bit of the first byte, and later field bits run toward less significant bits and higher addresses. Opcode 0 (unsigned extract) returns the field zero-extended.
- R5: Opcode 1 (signed extract) returns the field sign-extended from its top bit.
- R6: Opcode 2 (insert) writes the low length bits of the value into the field and leaves all other bits of the touched bytes unchanged. Its result is the masked value, and its flags are taken from the inserted value.
- R7: Opcodes 3, 4 and 5 invert, clear and set every field bit, respectively. Their result is the original field, zero-extended, and their flags are taken from the original field.
- R8: Opcode 6 (find first one) returns the original bit offset plus the number of leading zeros in the field. If the field is all zero, it returns the offset plus the length.
- R9: N is the top bit of the flag source and Z is set when the flag source is zero. For all opcodes other than insert, the flag source is the original field.
- R10: The modifying opcodes (2 to 5) read all bytes before writing any, then write the same bytes in ascending address order. Opcodes 0, 1, 6 and 7 never write.
- R11: `done` is high for exactly one cycle, the cycle after the last memory handshake. `cmd_ready` is high only when no command is in progress.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction and write data stay unchanged on the next cycle.
- R13: Opcode 7 behaves like unsigned extract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted this cycle if offered |
| cmd_op | input | 3 | Opcode, 0..7 as in R4-R8, R13 |
| cmd_base | input | AW | Base byte address |
| cmd_offset | input | OFW | Signed bit offset |
| cmd_len | input | 5 | Length code, 0 means 32 |
| cmd_value | input | FW | Value for insert |
| mem_req_valid | output | 1 | Memory transaction requested |
| mem_req_ready | input | 1 | Memory accepts the transaction this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, sampled on a read handshake |
| done | output | 1 | One-cycle completion pulse |
| result | output | FW | Result word, valid with done |
| flag_n | output | 1 | N flag, valid with done |
| flag_z | output | 1 | Z flag, valid with done |

## Verification
Two functions can fall on the same edge: the last read handshake, and the start of write-back on the next cycle. At that point the new bytes must already reflect the freshly captured window. Memory back-pressure can also coincide with a phase change, so a stalled request must stay frozen across it. The bench provokes both by throttling `mem_req_ready` from a pseudo-random sequence, including stalls on the first write and on the final read. It judges the outcome by comparing every handshake address in order, the read and write counts, the `done` cycle, and the whole memory image against a bit-by-bit reference model.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    BF_EXTU = 3'd0,
    BF_EXTS = 3'd1,
    BF_INS  = 3'd2,
    BF_CHG  = 3'd3,
    BF_CLR  = 3'd4,
    BF_SET  = 3'd5,
    BF_FFO  = 3'd6,
    BF_RSV  = 3'd7
  } bf_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2,
    SQ_DONE  = 2'd3
  } bf_state_e;

  function automatic logic bf_is_modify(bf_op_e op);
    return (op == BF_INS) || (op == BF_CHG) || (op == BF_CLR) || (op == BF_SET);
  endfunction
endpackage

// File: rtl/bf_addr_plan.sv
module bf_addr_plan #(
  parameter int AW  = 32,
  parameter int OFW = 32,
  parameter int FW  = 32,
  localparam int LW = $clog2(FW),
  localparam int NB = FW / 8 + 1,
  localparam int IW = $clog2(NB)
) (
  input  logic [AW-1:0]  base,
  input  logic [OFW-1:0] offset,
  input  logic [LW-1:0]  len_code,
  output logic [LW:0]    eff_len,
  output logic [AW-1:0]  byte_addr,
  output logic [2:0]     bit_ofs,
  output logic [IW-1:0]  last_idx
);
  localparam logic [LW:0] FWL = (LW+1)'(FW);

  logic signed [OFW-1:0] byte_step;
  logic [LW+1:0]         span;

  // zero code selects full width
  assign eff_len   = (len_code == '0) ? FWL : {1'b0, len_code};
  // arithmetic shift rounds toward negative infinity
  assign byte_step = $signed(offset) >>> 3;
  assign byte_addr = base + AW'(byte_step);
  assign bit_ofs   = offset[2:0];
  assign span      = (LW+2)'(bit_ofs) + (LW+2)'(eff_len) - (LW+2)'(1);
  assign last_idx  = IW'(span >> 3);
endmodule

// File: rtl/bf_field_alu.sv
module bf_field_alu
  import bf_pkg::*;
#(
  parameter int FW  = 32,
  parameter int OFW = 32,
  localparam int LW = $clog2(FW),
  localparam int NB = FW / 8 + 1,
  localparam int WW = NB * 8,
  localparam int SW = $clog2(WW) + 1
) (
  input  logic [WW-1:0]  window,
  input  logic [2:0]     bit_ofs,
  input  logic [LW:0]    eff_len,
  input  bf_op_e         op,
  input  logic [FW-1:0]  ins_val,
  input  logic [OFW-1:0] offset,
  output logic [FW-1:0]  result,
  output logic           flag_n,
  output logic           flag_z,
  output logic [WW-1:0]  new_window
);
  localparam logic [LW:0] FWL = (LW+1)'(FW);

  logic [SW-1:0] low_gap;
  logic [FW-1:0] low_mask;
  logic [WW-1:0] win_mask;
  logic [FW-1:0] field;
  logic [FW-1:0] ins_bits;
  logic [FW-1:0] aligned;
  logic [LW-1:0] top_idx;
  logic          field_top;
  logic [LW:0]   lead_zeros;
  logic          seen_one;

  // bits below the field inside the window
  assign low_gap  = SW'(WW) - SW'(bit_ofs) - SW'(eff_len);
  assign low_mask = {FW{1'b1}} >> (FWL - eff_len);
  assign win_mask = WW'(low_mask) << low_gap;
  assign field    = FW'(window >> low_gap) & low_mask;
  assign ins_bits = ins_val & low_mask;
  assign top_idx  = LW'(eff_len - (LW+1)'(1));
  assign field_top = field[top_idx];
  assign aligned  = field << (FWL - eff_len);

  always_comb begin
    lead_zeros = eff_len;
    seen_one   = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (!seen_one && aligned[i]) begin
        lead_zeros = (LW+1)'(FW - 1 - i);
        seen_one   = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (op)
      BF_INS:  new_window = (window & ~win_mask) | (WW'(ins_bits) << low_gap);
      BF_CHG:  new_window = window ^ win_mask;
      BF_CLR:  new_window = window & ~win_mask;
      BF_SET:  new_window = window | win_mask;
      default: new_window = window;
    endcase
  end

  always_comb begin
    unique case (op)
      BF_EXTS: result = field_top ? (field | ~low_mask) : field;
      BF_INS:  result = ins_bits;
      BF_FFO:  result = FW'(offset) + FW'(lead_zeros);
      default: result = field;
    endcase
    if (op == BF_INS) begin
      flag_n = ins_bits[top_idx];
      flag_z = (ins_bits == '0);
    end else begin
      flag_n = field_top;
      flag_z = (field == '0);
    end
  end
endmodule

// File: rtl/bf_mem_seq.sv
module bf_mem_seq
  import bf_pkg::*;
#(
  parameter int AW  = 32,
  parameter int FW  = 32,
  localparam int NB = FW / 8 + 1,
  localparam int IW = $clog2(NB),
  localparam int WW = NB * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          modify,
  input  logic [AW-1:0] first_addr,
  input  logic [IW-1:0] last_idx,
  input  logic [WW-1:0] new_window,
  output logic          idle,
  output logic          done,
  output logic [WW-1:0] window,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [7:0]    mem_req_wdata,
  input  logic [7:0]    mem_rdata
);
  bf_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic          hs;
  logic          at_last;

  assign mem_req_valid = (state_q == SQ_READ) || (state_q == SQ_WRITE);
  assign mem_req_write = (state_q == SQ_WRITE);
  assign mem_req_addr  = first_addr + AW'(idx_q);
  assign mem_req_wdata = new_window[WW - 1 - 8 * int'(idx_q) -: 8];
  assign hs            = mem_req_valid && mem_req_ready;
  assign at_last       = (idx_q == last_idx);
  assign idle          = (state_q == SQ_IDLE);
  assign done          = (state_q == SQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      window  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_READ;
          idx_q   <= '0;
          window  <= '0;
        end
        SQ_READ: if (hs) begin
          window[WW - 1 - 8 * int'(idx_q) -: 8] <= mem_rdata;
          if (at_last) begin
            idx_q   <= '0;
            state_q <= modify ? SQ_WRITE : SQ_DONE;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        SQ_WRITE: if (hs) begin
          if (at_last) begin
            idx_q   <= '0;
            state_q <= SQ_DONE;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_addr_ascend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !at_last) |=> (mem_req_addr == $past(mem_req_addr) + AW'(1)));

  assert_write_only_modify_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> modify);
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bf_pkg::*;
#(
  parameter int AW  = 32,
  parameter int FW  = 32,
  parameter int OFW = 32,
  localparam int LW = $clog2(FW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [AW-1:0]  cmd_base,
  input  logic [OFW-1:0] cmd_offset,
  input  logic [LW-1:0]  cmd_len,
  input  logic [FW-1:0]  cmd_value,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic [AW-1:0]  mem_req_addr,
  output logic [7:0]     mem_req_wdata,
  input  logic [7:0]     mem_rdata,
  output logic           done,
  output logic [FW-1:0]  result,
  output logic           flag_n,
  output logic           flag_z
);
  localparam int NB = FW / 8 + 1;
  localparam int IW = $clog2(NB);
  localparam int WW = NB * 8;

  logic [LW:0]    plan_len;
  logic [AW-1:0]  plan_addr;
  logic [2:0]     plan_bofs;
  logic [IW-1:0]  plan_last;

  bf_op_e         op_q;
  logic [AW-1:0]  addr_q;
  logic [OFW-1:0] ofs_q;
  logic [LW:0]    len_q;
  logic [2:0]     bofs_q;
  logic [IW-1:0]  last_q;
  logic [FW-1:0]  val_q;

  logic           accept;
  logic           seq_idle;
  logic           seq_done;
  logic [WW-1:0]  window;
  logic [WW-1:0]  new_window;
  logic [FW-1:0]  alu_result;
  logic           alu_n;
  logic           alu_z;

  bf_addr_plan #(.AW(AW), .OFW(OFW), .FW(FW)) u_plan (
    .base      (cmd_base),
    .offset    (cmd_offset),
    .len_code  (cmd_len),
    .eff_len   (plan_len),
    .byte_addr (plan_addr),
    .bit_ofs   (plan_bofs),
    .last_idx  (plan_last)
  );

  assign cmd_ready = seq_idle;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= BF_EXTU;
      addr_q <= '0;
      ofs_q  <= '0;
      len_q  <= '0;
      bofs_q <= '0;
      last_q <= '0;
      val_q  <= '0;
    end else if (accept) begin
      op_q   <= bf_op_e'(cmd_op);
      addr_q <= plan_addr;
      ofs_q  <= cmd_offset;
      len_q  <= plan_len;
      bofs_q <= plan_bofs;
      last_q <= plan_last;
      val_q  <= cmd_value;
    end
  end

  bf_mem_seq #(.AW(AW), .FW(FW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .modify        (bf_is_modify(op_q)),
    .first_addr    (addr_q),
    .last_idx      (last_q),
    .new_window    (new_window),
    .idle          (seq_idle),
    .done          (seq_done),
    .window        (window),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rdata     (mem_rdata)
  );

  bf_field_alu #(.FW(FW), .OFW(OFW)) u_alu (
    .window     (window),
    .bit_ofs    (bofs_q),
    .eff_len    (len_q),
    .op         (op_q),
    .ins_val    (val_q),
    .offset     (ofs_q),
    .result     (alu_result),
    .flag_n     (alu_n),
    .flag_z     (alu_z),
    .new_window (new_window)
  );

  assign done   = seq_done;
  assign result = seq_done ? alu_result : '0;
  assign flag_n = seq_done & alu_n;
  assign flag_z = seq_done & alu_z;

  assert_len_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (plan_len != '0 && plan_len <= (LW+1)'(FW)));

  assert_span_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (plan_last <= IW'(NB - 1)));

  assert_ffo_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == BF_FFO && flag_z) |-> (result == FW'(ofs_q) + FW'(len_q)));
endmodule

// File: tb/bitfield_mem_unit_test.sv
module bitfield_mem_unit_test;
  typedef struct {
    logic [31:0] res;
    logic        n;
    logic        z;
    int          reads;
    int          writes;
    logic [7:0]  first;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_base = '0;
  logic [31:0] cmd_offset = '0;
  logic [4:0]  cmd_len = '0;
  logic [31:0] cmd_value = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [31:0] result;
  logic        flag_n;
  logic        flag_z;

  logic [7:0]  mem    [0:255];
  logic [7:0]  refmem [0:255];
  exp_t        q[$];
  int          n_tests = 0;
  int          n_fail = 0;
  bit          stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  bitfield_mem_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_base(cmd_base), .cmd_offset(cmd_offset), .cmd_len(cmd_len),
    .cmd_value(cmd_value), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata), .done(done),
    .result(result), .flag_n(flag_n), .flag_z(flag_z)
  );

  assign mem_rdata = mem[mem_req_addr[7:0]];

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready && mem_req_write)
      mem[mem_req_addr[7:0]] <= mem_req_wdata;
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready = stall_mode ? (lfsr[0] & lfsr[3]) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bit-serial reference model over refmem
  task automatic ref_op(input logic [2:0] op, input logic [31:0] base, input int off,
                        input logic [4:0] lenf, input logic [31:0] val, output exp_t e);
    int len;
    longint bp0;
    logic [31:0] f;
    logic [31:0] mask;
    int lz;
    bit modify;
    len  = (lenf == 0) ? 32 : int'(lenf);
    bp0  = longint'(base) * 8 + longint'(off);
    f    = '0;
    mask = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    modify = (op >= 3'd2) && (op <= 3'd5);
    for (int i = 0; i < len; i++) begin
      longint bp = bp0 + i;
      longint by = bp >>> 3;
      int bi = 7 - int'(bp & 7);
      f = {f[30:0], refmem[by[7:0]][bi]};
    end
    for (int i = 0; i < len; i++) begin
      longint bp = bp0 + i;
      longint by = bp >>> 3;
      int bi = 7 - int'(bp & 7);
      case (op)
        3'd2: refmem[by[7:0]][bi] = val[len-1-i];
        3'd3: refmem[by[7:0]][bi] = ~refmem[by[7:0]][bi];
        3'd4: refmem[by[7:0]][bi] = 1'b0;
        3'd5: refmem[by[7:0]][bi] = 1'b1;
        default: ;
      endcase
    end
    lz = len;
    for (int i = 0; i < len; i++) if (lz == len && f[len-1-i]) lz = i;
    e.n = f[len-1];
    e.z = (f == 0);
    case (op)
      3'd1: e.res = f[len-1] ? (f | ~mask) : f;
      3'd2: begin
        e.res = val & mask;
        e.n = val[len-1];
        e.z = ((val & mask) == 0);
      end
      3'd6: e.res = 32'(off + lz);
      default: e.res = f;
    endcase
    e.reads  = (int'(bp0 & 7) + len - 1) / 8 + 1;
    e.writes = modify ? e.reads : 0;
    begin
      longint fb = bp0 >>> 3;
      e.first = fb[7:0];
    end
  endtask

  task automatic poke(input int a, input logic [7:0] v);
    mem[a] = v;
    refmem[a] = v;
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] base, input int off,
                     input logic [4:0] lenf, input logic [31:0] val, input string req,
                     input bit stall);
    exp_t e;
    stall_mode = stall;
    ref_op(op, base, off, lenf, val, e);
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_base = base; cmd_offset = off;
    cmd_len = lenf; cmd_value = val;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  int     rd_cnt = 0;
  int     wr_cnt = 0;
  longint cyc = 0;
  longint last_hs = -10;
  bit     prev_stall = 1'b0;
  logic [31:0] prev_addr;
  logic        prev_wr;
  logic [7:0]  prev_wdata;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_stall) begin
        chk(mem_req_valid && mem_req_addr == prev_addr && mem_req_write == prev_wr
            && mem_req_wdata == prev_wdata, "R12", "held request", mem_req_addr, prev_addr);
      end
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      prev_wr    = mem_req_write;
      prev_wdata = mem_req_wdata;
      if (mem_req_valid && mem_req_ready && q.size() != 0) begin
        last_hs = cyc;
        if (mem_req_write) begin
          chk(mem_req_addr[7:0] == q[0].first + 8'(wr_cnt), "R10", "write address",
              mem_req_addr[7:0], q[0].first + 8'(wr_cnt));
          wr_cnt++;
        end else begin
          chk(wr_cnt == 0, "R10", "read after write", wr_cnt, 0);
          chk(mem_req_addr[7:0] == q[0].first + 8'(rd_cnt), "R2", "read address",
              mem_req_addr[7:0], q[0].first + 8'(rd_cnt));
          rd_cnt++;
        end
      end
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          bit same;
          e = q.pop_front();
          chk(cyc == last_hs + 1, "R11", "done cycle", cyc - last_hs, 1);
          chk(result == e.res, e.req, "result", result, e.res);
          chk(flag_n == e.n, "R9", "flag N", flag_n, e.n);
          chk(flag_z == e.z, "R9", "flag Z", flag_z, e.z);
          chk(rd_cnt == e.reads, "R3", "read count", rd_cnt, e.reads);
          chk(wr_cnt == e.writes, "R10", "write count", wr_cnt, e.writes);
          same = 1'b1;
          for (int i = 0; i < 256; i++) if (mem[i] !== refmem[i]) same = 1'b0;
          chk(same, e.req, "memory image", same, 1);
        end
        rd_cnt = 0;
        wr_cnt = 0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) poke(i, 8'(i * 29 + 7));
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_ready == 1'b1, "R11", "reset cmd_ready", cmd_ready, 1);
    chk(mem_req_valid == 1'b0, "R11", "reset mem_req_valid", mem_req_valid, 0);
    chk(done == 1'b0, "R11", "reset done", done, 0);
    rst_n = 1'b1;
    // R4: aligned byte, unsigned extract
    poke(100, 8'hA5);
    run(3'd0, 32'd100, 0, 5'd8, 0, "R4", 1'b0);
    // R1: length code 0 is a full word, 4 bytes
    run(3'd0, 32'd100, 0, 5'd0, 0, "R1", 1'b0);
    // R3: in-byte offset 7 with 32 bits spans five bytes
    run(3'd0, 32'd50, 7, 5'd0, 0, "R3", 1'b1);
    // R5: signed extract of negative and positive fields
    poke(120, 8'b0110_1000);
    run(3'd1, 32'd120, 1, 5'd4, 0, "R5", 1'b0);
    run(3'd1, 32'd120, 0, 5'd4, 0, "R5", 1'b1);
    // R2: negative offsets reach below the base
    run(3'd0, 32'd100, -3, 5'd9, 0, "R2", 1'b1);
    run(3'd1, 32'd100, -17, 5'd12, 0, "R2", 1'b0);
    // R6: insert across a byte boundary, only low bits used
    run(3'd2, 32'd60, 5, 5'd10, 32'hFFFF_F2B7, "R6", 1'b1);
    run(3'd2, 32'd70, -6, 5'd0, 32'h8001_0203, "R6", 1'b0);
    run(3'd2, 32'd72, 3, 5'd3, 32'h0000_0008, "R6", 1'b1);
    // R7: change, clear, set
    run(3'd3, 32'd80, 6, 5'd13, 0, "R7", 1'b1);
    run(3'd4, 32'd85, -2, 5'd20, 0, "R7", 1'b0);
    run(3'd5, 32'd90, 12, 5'd1, 0, "R7", 1'b1);
    // R8: find first one, found and empty field
    poke(140, 8'h00); poke(141, 8'h04); poke(142, 8'hFF);
    run(3'd6, 32'd140, 3, 5'd16, 0, "R8", 1'b0);
    poke(150, 8'h80); poke(151, 8'h00); poke(152, 8'h01);
    run(3'd6, 32'd150, 1, 5'd14, 0, "R8", 1'b1);
    run(3'd6, 32'd151, -9, 5'd20, 0, "R8", 1'b0);
    // R13: reserved opcode extracts and never writes
    run(3'd7, 32'd110, 4, 5'd17, 0, "R13", 1'b1);
    // R10: modifying op under heavy stalls, then read back
    run(3'd3, 32'd50, 7, 5'd0, 0, "R10", 1'b1);
    run(3'd0, 32'd50, 7, 5'd0, 0, "R10", 1'b0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule